// File: doc/BRIEF.md
# Peripheral Module Stop Controller

This block decides, per peripheral, when its clock may be switched off and when it must come back. Software sets bits in a stop-request register. For each selected peripheral the controller raises a quiesce request and waits, for as long as it takes, until the peripheral reports that it is safe to stop. It then drops that peripheral's clock enable and sets a read-only acknowledge bit. The enable feeds a latch-based, glitch-free clock gating cell outside the block. While a peripheral is acknowledged as stopped, any bus access aimed at it is answered with an error and any memory request it raises is blocked.

Clearing a request bit reverses the sequence. The clock enable comes back first. The acknowledge bit clears one cycle after the peripheral reports ready.

The block also follows the chip-level low-power state. A sleep command from the CPU moves the chip into sleep mode or standby mode, and a standby bit chooses between them. In sleep mode only the CPU and the already selected peripherals are low power. In standby mode every peripheral is quiesced, whatever the request register holds, and the clock controller is told to stop. A wake-up interrupt returns the chip to run mode. After wake-up only the peripherals still selected in the request register stay stopped.

Top module: `pmstop_ctrl`

## Requirements
- R1: After reset the request register, the acknowledge vector and the standby bit are 0, every clock enable is 1, no quiesce request is raised and the chip mode is run (`mode_o` = 2'b00).
- R2: A request-register write is visible on `stopreq_o` after the next clock edge. The quiesce request of each newly selected peripheral rises one edge later.
- R3: A peripheral's clock enable falls, and its acknowledge bit rises, on the first edge at which its quiesce request and its safe input are both high, and never earlier. The wait before that edge may be any number of cycles.
- R4: `acc_err_o` is 1 exactly when `acc_valid_i` is 1 and `acc_sel_i` (a peripheral index, 0 to N-1) names a peripheral whose acknowledge bit is 1.
- R5: `mem_req_o[i]` passes `mem_req_i[i]` when acknowledge bit i is 0 and is forced to 0 when it is 1.
- R6: Clearing a stopped peripheral's request bit raises its clock enable two edges after the write, while its acknowledge stays 1. The acknowledge clears on the edge at which `ready_i` is sampled high, and the peripheral is back in run state.
- R7: In run mode with the standby bit 0, a `sleep_i` pulse sets `mode_o` to 2'b01 on the next edge. `cpu_lp_o` is then 1 and `clkctl_run_o` stays 1. Peripherals that are not selected keep running.
- R8: In run mode with the standby bit 1, a `sleep_i` pulse sets `mode_o` to 2'b10 and `clkctl_run_o` to 0. Every peripheral is then quiesced and stopped, whatever its request bit holds.
- R9: `wake_i` in sleep or standby mode sets `mode_o` to 2'b00 on the next edge. Peripherals not selected in the request register start their power-up one edge later. Selected peripherals stay stopped.
- R10: Clearing a request bit while the peripheral is still waiting for its safe input withdraws the quiesce request one edge after the register changes. No acknowledge is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stopreq_wr_i | input | 1 | Write strobe for the request register |
| stopreq_wdata_i | input | N | New request register value |
| stby_wr_i | input | 1 | Write strobe for the standby bit |
| stby_wdata_i | input | 1 | New standby bit value |
| stopreq_o | output | N | Request register read value |
| stopack_o | output | N | Acknowledge vector, 1 = peripheral fully stopped |
| stby_o | output | 1 | Standby bit read value |
| quiesce_req_o | output | N | Per-peripheral request to reach a safe point |
| safe_i | input | N | Per-peripheral safe-to-stop indication |
| ready_i | input | N | Per-peripheral running-again indication |
| clk_en_o | output | N | Per-peripheral clock enable for the external gating cell |
| acc_valid_i | input | 1 | Bus access present |
| acc_sel_i | input | max(1,log2 N) | Index of the addressed peripheral |
| acc_err_o | output | 1 | Error response for the current access |
| mem_req_i | input | N | Memory requests raised by the peripherals |
| mem_req_o | output | N | Memory requests passed on |
| sleep_i | input | 1 | CPU sleep command pulse |
| wake_i | input | 1 | Wake-up interrupt |
| mode_o | output | 2 | Chip mode: 00 run, 01 sleep, 10 standby |
| cpu_lp_o | output | 1 | CPU low-power indication |
| clkctl_run_o | output | 1 | Clock controller may run |

## Verification
The register, mode, clock enable and acknowledge results are due on fixed edges. The request register and the mode change one edge after their stimulus. A quiesce request rises one edge after the register bit, and the acknowledge and gate change one edge after safe or ready is seen. The access error and the memory mask are combinational and are due in the same cycle. The bench drives inputs shortly after a rising edge and samples shortly after the next one. For every stimulus it steps the exact number of edges listed above before comparing. To show that an early acknowledge does not occur, it holds the safe input low for several cycles and checks that the acknowledge stays 0.

// File: rtl/pmstop_pkg.sv
package pmstop_pkg;

    typedef enum logic [1:0] {
        MS_RUN     = 2'b00,
        MS_QUIESCE = 2'b01,
        MS_STOPPED = 2'b10,
        MS_WAKE    = 2'b11
    } mod_st_e;

    typedef enum logic [1:0] {
        CM_RUN     = 2'b00,
        CM_SLEEP   = 2'b01,
        CM_STANDBY = 2'b10
    } chip_mode_e;

endpackage

// File: rtl/pmstop_mod_fsm.sv
module pmstop_mod_fsm
    import pmstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_i,
    input  logic safe_i,
    input  logic ready_i,
    output logic quiesce_o,
    output logic clk_en_o,
    output logic ack_o
);

    mod_st_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            MS_RUN:     if (stop_i) st_d = MS_QUIESCE;
            MS_QUIESCE: begin
                if (!stop_i)     st_d = MS_RUN;
                else if (safe_i) st_d = MS_STOPPED;
            end
            MS_STOPPED: if (!stop_i) st_d = MS_WAKE;
            MS_WAKE:    if (ready_i) st_d = MS_RUN;
            default:    st_d = MS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MS_RUN;
        else        st_q <= st_d;
    end

    assign quiesce_o = (st_q == MS_QUIESCE) || (st_q == MS_STOPPED);
    assign clk_en_o  = (st_q != MS_STOPPED);
    assign ack_o     = (st_q == MS_STOPPED) || (st_q == MS_WAKE);

endmodule

// File: rtl/pmstop_mode.sv
module pmstop_mode
    import pmstop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_i,
    input  logic       wake_i,
    input  logic       stby_i,
    output chip_mode_e mode_o
);

    chip_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (mode_q == CM_RUN) begin
            if (sleep_i) mode_d = stby_i ? CM_STANDBY : CM_SLEEP;
        end else if (wake_i) begin
            mode_d = CM_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= CM_RUN;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/pmstop_fence.sv
module pmstop_fence #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          acc_valid_i,
    input  logic [IW-1:0] acc_sel_i,
    input  logic [N-1:0]  ack_i,
    input  logic [N-1:0]  mem_req_i,
    output logic          acc_err_o,
    output logic [N-1:0]  mem_req_o
);

    always_comb begin
        acc_err_o = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (acc_valid_i && (32'(acc_sel_i) == i) && ack_i[i]) acc_err_o = 1'b1;
        end
    end

    assign mem_req_o = mem_req_i & ~ack_i;

endmodule

// File: rtl/pmstop_ctrl.sv
module pmstop_ctrl
    import pmstop_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stopreq_wr_i,
    input  logic [N-1:0]  stopreq_wdata_i,
    input  logic          stby_wr_i,
    input  logic          stby_wdata_i,
    output logic [N-1:0]  stopreq_o,
    output logic [N-1:0]  stopack_o,
    output logic          stby_o,
    output logic [N-1:0]  quiesce_req_o,
    input  logic [N-1:0]  safe_i,
    input  logic [N-1:0]  ready_i,
    output logic [N-1:0]  clk_en_o,
    input  logic          acc_valid_i,
    input  logic [IW-1:0] acc_sel_i,
    output logic          acc_err_o,
    input  logic [N-1:0]  mem_req_i,
    output logic [N-1:0]  mem_req_o,
    input  logic          sleep_i,
    input  logic          wake_i,
    output logic [1:0]    mode_o,
    output logic          cpu_lp_o,
    output logic          clkctl_run_o
);

    typedef struct packed {
        logic [N-1:0] stopreq;
        logic         stby;
    } cfg_t;

    cfg_t       cfg_d, cfg_q;
    chip_mode_e mode;
    logic [N-1:0] stop_eff;

    always_comb begin
        cfg_d = cfg_q;
        if (stopreq_wr_i) cfg_d.stopreq = stopreq_wdata_i;
        if (stby_wr_i)    cfg_d.stby    = stby_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    pmstop_mode i_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep_i),
        .wake_i  (wake_i),
        .stby_i  (cfg_q.stby),
        .mode_o  (mode)
    );

    assign stop_eff = (mode == CM_STANDBY) ? {N{1'b1}} : cfg_q.stopreq;

    for (genvar g = 0; g < N; g++) begin : g_mod
        pmstop_mod_fsm i_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .stop_i    (stop_eff[g]),
            .safe_i    (safe_i[g]),
            .ready_i   (ready_i[g]),
            .quiesce_o (quiesce_req_o[g]),
            .clk_en_o  (clk_en_o[g]),
            .ack_o     (stopack_o[g])
        );
    end

    pmstop_fence #(.N(N), .IW(IW)) i_fence (
        .acc_valid_i (acc_valid_i),
        .acc_sel_i   (acc_sel_i),
        .ack_i       (stopack_o),
        .mem_req_i   (mem_req_i),
        .acc_err_o   (acc_err_o),
        .mem_req_o   (mem_req_o)
    );

    assign stopreq_o    = cfg_q.stopreq;
    assign stby_o       = cfg_q.stby;
    assign mode_o       = mode;
    assign cpu_lp_o     = (mode != CM_RUN);
    assign clkctl_run_o = (mode != CM_STANDBY);

endmodule

// File: rtl/pmstop_chk.sv
module pmstop_chk #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  stopack_o,
    input logic [N-1:0]  quiesce_req_o,
    input logic [N-1:0]  safe_i,
    input logic [N-1:0]  ready_i,
    input logic [N-1:0]  clk_en_o,
    input logic          acc_valid_i,
    input logic [IW-1:0] acc_sel_i,
    input logic          acc_err_o,
    input logic [N-1:0]  mem_req_o,
    input logic          sleep_i,
    input logic [1:0]    mode_o,
    input logic          clkctl_run_o
);

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_ACK_AFTER_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stopack_o[i]) |-> $past(quiesce_req_o[i] && safe_i[i])); // R3
        AST_GATE_ONLY_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
            !clk_en_o[i] |-> stopack_o[i]); // R3
        AST_ACK_CLEAR_READY: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stopack_o[i]) |-> $past(ready_i[i])); // R6
        AST_MEM_FENCED: assert property (@(posedge clk) disable iff (!rst_n)
            stopack_o[i] |-> !mem_req_o[i]); // R5
        AST_ERR_ON_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid_i && (32'(acc_sel_i) == i) && stopack_o[i]) |-> acc_err_o); // R4
    end

    AST_STANDBY_CLKCTL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> !clkctl_run_o); // R8
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 2'b00) && sleep_i) |=> (mode_o != 2'b00)); // R7

endmodule

bind pmstop_ctrl pmstop_chk #(.N(N)) i_chk (.*);

// File: tb/test_pmstop_ctrl.sv
module test_pmstop_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stopreq_wr_i = 0, stby_wr_i = 0, stby_wdata_i = 0;
    logic [N-1:0] stopreq_wdata_i = '0, safe_i = '0, ready_i = '0, mem_req_i = '0;
    logic acc_valid_i = 0, sleep_i = 0, wake_i = 0;
    logic [IW-1:0] acc_sel_i = '0;
    logic [N-1:0] stopreq_o, stopack_o, quiesce_req_o, clk_en_o, mem_req_o;
    logic stby_o, acc_err_o, cpu_lp_o, clkctl_run_o;
    logic [1:0] mode_o;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmstop_ctrl #(.N(N)) i_pmstop_ctrl (.*);

    // fence vectors: {valid, sel[1:0], mem_in[3:0], exp_err, exp_mem[3:0]}, with peripherals 1 and 3 stopped
    localparam logic [11:0] FVEC [5] = '{
        12'b1_01_1111_1_0101,
        12'b1_00_0001_0_0001,
        12'b1_11_1000_1_0000,
        12'b0_11_1010_0_0000,
        12'b1_10_0110_0_0100
    };

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr_req(input logic [N-1:0] v);
        stopreq_wdata_i = v;
        stopreq_wr_i = 1;
        tick();
        stopreq_wr_i = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 stopreq", stopreq_o, 0);
        chk("R1 ack", stopack_o, 0);
        chk("R1 clk_en", clk_en_o, 4'hF);
        chk("R1 quiesce", quiesce_req_o, 0);
        chk("R1 mode", mode_o, 0);
        chk("R1 stby", stby_o, 0);

        // R2/R3 stop peripheral 1, safe held low for a while
        wr_req(4'b0010);
        chk("R2 stopreq visible", stopreq_o, 4'b0010);
        chk("R2 quiesce not yet", quiesce_req_o, 0);
        tick();
        chk("R2 quiesce raised", quiesce_req_o, 4'b0010);
        tick(5);
        chk("R3 no early ack", stopack_o, 0);
        chk("R3 clock still on", clk_en_o, 4'hF);
        safe_i[1] = 1;
        tick();
        chk("R3 ack set", stopack_o, 4'b0010);
        chk("R3 gate closed", clk_en_o, 4'b1101);

        // stop peripheral 3 with safe already high
        safe_i[3] = 1;
        wr_req(4'b1010);
        tick(2);
        chk("R3 ack 3", stopack_o, 4'b1010);

        // R4/R5 fence table
        for (int v = 0; v < 5; v++) begin
            acc_valid_i = FVEC[v][11];
            acc_sel_i   = FVEC[v][10:9];
            mem_req_i   = FVEC[v][8:5];
            #1;
            chk($sformatf("R4 err vec%0d", v), acc_err_o, FVEC[v][4]);
            chk($sformatf("R5 mem vec%0d", v), mem_req_o, FVEC[v][3:0]);
        end
        acc_valid_i = 0;
        mem_req_i = '0;

        // R10 withdraw during quiesce for peripheral 0
        wr_req(4'b1011);
        tick();
        chk("R10 quiesce 0 up", quiesce_req_o[0], 1);
        wr_req(4'b1010);
        tick();
        chk("R10 quiesce withdrawn", quiesce_req_o[0], 0);
        chk("R10 no ack", stopack_o, 4'b1010);

        // R6 power-up of peripheral 1
        wr_req(4'b1000);
        chk("R6 still stopped", clk_en_o[1], 0);
        tick();
        chk("R6 clock reopens", clk_en_o[1], 1);
        chk("R6 ack held", stopack_o, 4'b1010);
        tick(2);
        chk("R6 ack held no ready", stopack_o[1], 1);
        ready_i[1] = 1;
        tick();
        chk("R6 ack cleared", stopack_o, 4'b1000);
        acc_valid_i = 1; acc_sel_i = 2'd1; #1;
        chk("R6 no error after", acc_err_o, 0);
        acc_valid_i = 0;
        ready_i = '0;

        // R7 sleep mode
        safe_i = 4'hF;
        sleep_i = 1; tick(); sleep_i = 0;
        chk("R7 mode sleep", mode_o, 2'b01);
        chk("R7 cpu lp", cpu_lp_o, 1);
        chk("R7 clkctl runs", clkctl_run_o, 1);
        tick(3);
        chk("R7 unselected running", stopack_o, 4'b1000);
        wake_i = 1; tick(); wake_i = 0;
        chk("R9 back to run", mode_o, 2'b00);

        // R8 standby mode
        stby_wdata_i = 1; stby_wr_i = 1; tick(); stby_wr_i = 0;
        chk("R8 stby set", stby_o, 1);
        sleep_i = 1; tick(); sleep_i = 0;
        chk("R8 mode standby", mode_o, 2'b10);
        chk("R8 clkctl stopped", clkctl_run_o, 0);
        tick();
        chk("R8 all quiesced", quiesce_req_o, 4'hF);
        tick();
        chk("R8 all stopped", stopack_o, 4'hF);
        chk("R8 all gated", clk_en_o, 4'h0);

        // R9 wake from standby
        wake_i = 1; tick(); wake_i = 0;
        chk("R9 mode run", mode_o, 2'b00);
        chk("R9 clkctl runs", clkctl_run_o, 1);
        tick();
        chk("R9 unselected clocks back", clk_en_o, 4'b0111);
        ready_i = 4'hF;
        tick();
        chk("R9 selected stays stopped", stopack_o, 4'b1000);
        ready_i = '0;

        finish_run();
    end

endmodule